// File: doc/BRIEF.md
# DMA Stall Length Arbiter

This block sits beside a 6502-style CPU core and decides how long the CPU must be held off the bus when the audio sample unit asks for a byte over DMA. A one-cycle request strobe arrives, and the arbiter looks at the bus activity in that same cycle. That activity can be an ordinary CPU read, a CPU write, the write that starts a sprite-table DMA, or one of the cycles of a sprite-table DMA that is already running. From this the arbiter picks a stall length of one to four cycles. It holds the CPU halt line for exactly that many cycles and pulses a fetch strobe on the last of them, which is the cycle in which the sample byte is read.

Requests that arrive while a stall is running, or while earlier requests are still waiting, go into a small queue. Each queued entry keeps the length computed when it arrived. Stalls never merge: after each stall the halt line drops for at least one cycle before the next queued stall begins. A request that arrives while the queue is full is discarded.

Top module: `dma_stall_arb`

## Requirements
- R1: A request sampled with `cpu_wr_i`=0, `trig_wr_i`=0 and `spr_active_i`=0 (an ordinary read cycle) produces a 4-cycle stall.
- R2: A request sampled with `cpu_wr_i`=1 and no sprite DMA or trigger write produces a 3-cycle stall. This includes the write cycle of an absolute store instruction.
- R3: A request sampled with `trig_wr_i`=1 and no active sprite DMA, or with `spr_active_i`=1 and `spr_left_i` of 0 or of 4 or more, produces a 2-cycle stall.
- R4: A request sampled with `spr_active_i`=1 and `spr_left_i`=3 (third-from-last sprite-DMA cycle) produces a 1-cycle stall.
- R5: A request sampled with `spr_active_i`=1 and `spr_left_i`=2 (second-from-last sprite-DMA cycle) produces a 2-cycle stall.
- R6: A request sampled with `spr_active_i`=1 and `spr_left_i`=1 (last sprite-DMA cycle) produces a 3-cycle stall.
- R7: Priority when several status inputs are high: an active sprite DMA decides first, then the trigger write, then the CPU write.
- R8: With the arbiter idle and the queue empty, `cpu_halt_o` rises in the cycle after the clock edge that samples the request and stays high for exactly the computed length. This also applies to a request arriving in the low cycle that follows a stall.
- R9: `fetch_o` is high for exactly one cycle, the last cycle of each stall, and `cpu_halt_o` is low in the cycle after it.
- R10: A request arriving during a stall is queued with the length sampled at its own edge. It is served in arrival order after exactly one low cycle of `cpu_halt_o`.
- R11: A request arriving in the low cycle between stalls while the queue holds entries is appended behind them, while the head entry starts at that same edge.
- R12: The queue holds up to `QDEPTH` waiting requests. A request arriving while the queue is full and no entry leaves is ignored and causes no stall.
- R13: During and directly after reset, `cpu_halt_o` and `fetch_o` are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_req_i | input | 1 | One-cycle sample-DMA request strobe |
| cpu_wr_i | input | 1 | 1 when the current CPU bus cycle is a write |
| trig_wr_i | input | 1 | 1 when the current cycle writes the sprite-DMA trigger register |
| spr_active_i | input | 1 | 1 while the sprite-DMA engine is transferring |
| spr_left_i | input | CNT_W | Sprite-DMA cycles remaining, the current one included (1 = last) |
| cpu_halt_o | output | 1 | CPU halt (not-ready), high during a stall |
| fetch_o | output | 1 | One-cycle strobe to fetch the sample byte |

## Verification
The classifier is swept over every combination of write, trigger-write and sprite-active status, together with remaining counts around the tail (0 to 5) and deep in the transfer. Each combination's stall length is compared with an arithmetic model of the priority rules. This separates the final three sprite-DMA cycles from each other and from the body. It also shows which status input wins when several are high. Timing traces of the halt and fetch lines are then taken under back-to-back requests: queued during a stall, arriving in the low gap with and without waiting entries, and overfilling the queue. These traces tell apart merging from proper sequencing, lost order from preserved order, and a dropped request from an accepted one.

// File: rtl/dma_stall_pkg.sv
// Shared types for the DMA stall arbiter: landing-cycle kinds and the
// stall length each one costs. Assumes stall lengths never exceed 4.
package dma_stall_pkg;

    localparam int LEN_W = 3;
    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [2:0] {
        LAND_READ     = 3'd0,
        LAND_WRITE    = 3'd1,
        LAND_TRIG     = 3'd2,
        LAND_SPR_BODY = 3'd3,
        LAND_SPR_M3   = 3'd4,
        LAND_SPR_M2   = 3'd5,
        LAND_SPR_M1   = 3'd6
    } land_e;

    // Map a landing kind to the number of stolen CPU cycles.
    function automatic len_t land_len(land_e kind);
        case (kind)
            LAND_READ:     return len_t'(4);
            LAND_WRITE:    return len_t'(3);
            LAND_TRIG:     return len_t'(2);
            LAND_SPR_BODY: return len_t'(2);
            LAND_SPR_M3:   return len_t'(1);
            LAND_SPR_M2:   return len_t'(2);
            LAND_SPR_M1:   return len_t'(3);
            default:       return len_t'(4);
        endcase
    endfunction

endpackage

// File: rtl/dma_stall_classify.sv
// Combinational classifier: decides which kind of bus cycle a DMA request
// lands on and returns the resulting stall length.
// Assumes spr_left_i counts the current sprite-DMA cycle (1 = last).
module dma_stall_classify
    import dma_stall_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             cpu_wr_i,
    input  logic             trig_wr_i,
    input  logic             spr_active_i,
    input  logic [CNT_W-1:0] spr_left_i,
    output len_t             len_o
);

    land_e kind;

    // Priority decode: sprite DMA, then trigger write, then CPU write.
    always_comb begin
        if (spr_active_i) begin
            if (spr_left_i == CNT_W'(1))      kind = LAND_SPR_M1;
            else if (spr_left_i == CNT_W'(2)) kind = LAND_SPR_M2;
            else if (spr_left_i == CNT_W'(3)) kind = LAND_SPR_M3;
            else                              kind = LAND_SPR_BODY;
        end else if (trig_wr_i) begin
            kind = LAND_TRIG;
        end else if (cpu_wr_i) begin
            kind = LAND_WRITE;
        end else begin
            kind = LAND_READ;
        end
        len_o = land_len(kind);
    end

endmodule

// File: rtl/dma_stall_queue.sv
// Small in-order queue of pending stall lengths. A push while full is
// ignored unless an entry leaves in the same cycle. Assumes DEPTH >= 2.
module dma_stall_queue
    import dma_stall_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  len_t push_len_i,
    input  logic pop_i,
    output len_t head_len_o,
    output logic empty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    len_t             slot [DEPTH];
    logic             full, accept, do_pop;

    assign empty_o    = (count == '0);
    assign full       = (count == CW'(DEPTH));
    assign do_pop     = pop_i && !empty_o;
    assign accept     = push_i && (!full || do_pop);
    assign head_len_o = slot[rd_ptr];

    // One storage register per queue slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                               slot[g] <= '0;
            else if (accept && wr_ptr == PTR_W'(g))   slot[g] <= push_len_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({accept, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R12
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (count == CW'(DEPTH))); // R12

endmodule

// File: rtl/dma_stall_timer.sv
// Stall timer: on start it holds halt high for the loaded number of cycles
// and flags the final one as the fetch cycle. Assumes len >= 1.
module dma_stall_timer
    import dma_stall_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  len_t start_len_i,
    output logic halt_o,
    output logic fetch_o
);

    len_t remain;

    // Load on start when idle, count down while halting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_o <= 1'b0;
            remain <= '0;
        end else if (!halt_o && start_i) begin
            halt_o <= 1'b1;
            remain <= start_len_i;
        end else if (halt_o) begin
            if (remain == len_t'(1)) halt_o <= 1'b0;
            else                     remain <= remain - 1'b1;
        end
    end

    assign fetch_o = halt_o && (remain == len_t'(1));

    AST_START_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !halt_o) |-> (start_len_i >= len_t'(1) && start_len_i <= len_t'(4))); // R1
    AST_FETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> !halt_o); // R9
    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> !fetch_o); // R9
    AST_FETCH_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> halt_o); // R9

endmodule

// File: rtl/dma_stall_arb.sv
// DMA stall length arbiter top: classifies each request against the bus
// cycle it lands on, queues requests that arrive while busy, and drives
// the CPU halt and sample-fetch strobe. Assumes one request per cycle.
module dma_stall_arb
    import dma_stall_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int QDEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_req_i,
    input  logic             cpu_wr_i,
    input  logic             trig_wr_i,
    input  logic             spr_active_i,
    input  logic [CNT_W-1:0] spr_left_i,
    output logic             cpu_halt_o,
    output logic             fetch_o
);

    len_t req_len, head_len, start_len;
    logic q_empty, q_push, q_pop, start;

    dma_stall_classify #(.CNT_W(CNT_W)) u_classify (
        .cpu_wr_i     (cpu_wr_i),
        .trig_wr_i    (trig_wr_i),
        .spr_active_i (spr_active_i),
        .spr_left_i   (spr_left_i),
        .len_o        (req_len)
    );

    // Steer a request to the timer directly or into the queue.
    always_comb begin
        q_pop     = 1'b0;
        q_push    = 1'b0;
        start     = 1'b0;
        start_len = req_len;
        if (cpu_halt_o) begin
            q_push = dma_req_i;
        end else if (!q_empty) begin
            q_pop     = 1'b1;
            start     = 1'b1;
            start_len = head_len;
            q_push    = dma_req_i;
        end else begin
            start = dma_req_i;
        end
    end

    dma_stall_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (q_push),
        .push_len_i (req_len),
        .pop_i      (q_pop),
        .head_len_o (head_len),
        .empty_o    (q_empty)
    );

    dma_stall_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_len_i (start_len),
        .halt_o      (cpu_halt_o),
        .fetch_o     (fetch_o)
    );

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_i && !cpu_halt_o && q_empty) |=> cpu_halt_o); // R8
    AST_QUEUED_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt_o && !q_empty) |=> cpu_halt_o); // R10

endmodule

// File: tb/dma_stall_arb_bench.sv
`timescale 1ns/1ps
module dma_stall_arb_bench;

    localparam int CNT_W  = 9;
    localparam int QDEPTH = 2;
    localparam int TLEN   = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_req_i = 1'b0, cpu_wr_i = 1'b0, trig_wr_i = 1'b0, spr_active_i = 1'b0;
    logic [CNT_W-1:0] spr_left_i = '0;
    logic cpu_halt_o, fetch_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic got_h [TLEN];
    logic got_f [TLEN];
    logic exp_h [TLEN];
    logic exp_f [TLEN];
    int gidx, eidx;

    always #2 clk = ~clk;

    dma_stall_arb #(.CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_dma_stall_arb (
        .clk(clk), .rst_n(rst_n), .dma_req_i(dma_req_i), .cpu_wr_i(cpu_wr_i),
        .trig_wr_i(trig_wr_i), .spr_active_i(spr_active_i), .spr_left_i(spr_left_i),
        .cpu_halt_o(cpu_halt_o), .fetch_o(fetch_o)
    );

    // Drive one cycle of inputs at the falling edge and record the outputs.
    task automatic tick(input bit rq, input bit w, input bit t, input bit a, input int left);
        @(negedge clk);
        dma_req_i = rq; cpu_wr_i = w; trig_wr_i = t; spr_active_i = a;
        spr_left_i = CNT_W'(left);
        if (gidx < TLEN) begin
            got_h[gidx] = cpu_halt_o;
            got_f[gidx] = fetch_o;
            gidx++;
        end
    endtask

    task automatic trace_clear();
        for (int i = 0; i < TLEN; i++) begin
            exp_h[i] = 1'b0; exp_f[i] = 1'b0;
        end
        gidx = 0;
        eidx = 1;
    endtask

    // Append one stall of length len and its trailing low cycle.
    task automatic exp_run(input int len);
        for (int i = 0; i < len; i++) begin
            exp_h[eidx + i] = 1'b1;
            exp_f[eidx + i] = (i == len - 1);
        end
        eidx += len + 1;
    endtask

    task automatic fill_idle();
        while (gidx < TLEN) tick(0, 0, 0, 0, 0);
    endtask

    task automatic trace_check(input string tag, input string what);
        int bad;
        bad = -1;
        for (int i = TLEN - 1; i >= 0; i--)
            if (got_h[i] !== exp_h[i] || got_f[i] !== exp_f[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s %s: cycle %0d halt/fetch actual %b/%b expected %b/%b",
                     tag, what, bad, got_h[bad], got_f[bad], exp_h[bad], exp_f[bad]);
        end
    endtask

    // Arithmetic model of the stall length from the requirements.
    function automatic int model_len(bit w, bit t, bit a, int left);
        if (a) begin
            if (left == 1) return 3;
            if (left == 2) return 2;
            if (left == 3) return 1;
            return 2;
        end
        if (t) return 2;
        if (w) return 3;
        return 4;
    endfunction

    function automatic string model_tag(bit w, bit t, bit a, int left);
        if ((a && (t || w)) || (t && w)) return "R7";
        if (a) begin
            if (left == 1) return "R6";
            if (left == 2) return "R5";
            if (left == 3) return "R4";
            return "R3";
        end
        if (t) return "R3";
        if (w) return "R2";
        return "R1";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int lefts [8];
        lefts = '{0, 1, 2, 3, 4, 5, 255, 256};

        // R13 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (cpu_halt_o !== 1'b0 || fetch_o !== 1'b0) begin
            errors++;
            $display("FAIL R13 in reset: actual %b/%b expected 0/0", cpu_halt_o, fetch_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cpu_halt_o !== 1'b0 || fetch_o !== 1'b0) begin
            errors++;
            $display("FAIL R13 after reset: actual %b/%b expected 0/0", cpu_halt_o, fetch_o);
        end

        // R1-style sweep: every status combination, stall shape per R8 and R9
        for (int w = 0; w < 2; w++)
            for (int t = 0; t < 2; t++)
                for (int a = 0; a < 2; a++)
                    for (int k = 0; k < 8; k++) begin
                        trace_clear();
                        tick(1, w[0], t[0], a[0], lefts[k]);
                        exp_run(model_len(w[0], t[0], a[0], lefts[k]));
                        fill_idle();
                        trace_check(model_tag(w[0], t[0], a[0], lefts[k]),
                                    $sformatf("w=%0d t=%0d a=%0d left=%0d", w, t, a, lefts[k]));
                    end

        // R8: request in the low cycle after a stall, queue empty
        trace_clear();
        tick(1, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0);
        exp_run(3); exp_run(4);
        fill_idle();
        trace_check("R8", "request in gap cycle");

        // R10: two requests queued during a stall, served in order
        trace_clear();
        tick(1, 0, 0, 0, 0);
        tick(1, 1, 0, 0, 0);
        tick(1, 0, 1, 0, 0);
        exp_run(4); exp_run(3); exp_run(2);
        fill_idle();
        trace_check("R10", "queued during stall");

        // R12: third request while queue full is dropped
        trace_clear();
        tick(1, 0, 0, 0, 0);
        tick(1, 1, 0, 0, 0);
        tick(1, 0, 1, 0, 0);
        tick(1, 0, 0, 0, 0);
        exp_run(4); exp_run(3); exp_run(2);
        fill_idle();
        trace_check("R12", "overfull queue");

        // R11: request in gap while queue holds an entry
        trace_clear();
        tick(1, 0, 0, 0, 0);
        tick(1, 1, 0, 0, 0);
        tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
        tick(1, 0, 0, 1, 2);
        exp_run(4); exp_run(3); exp_run(2);
        fill_idle();
        trace_check("R11", "push during pop");

        // R10: queued length sampled at its own edge (tail cycle, cost 1)
        trace_clear();
        tick(1, 0, 1, 0, 0);
        tick(1, 0, 0, 1, 3);
        exp_run(2); exp_run(1);
        fill_idle();
        trace_check("R10", "queued tail-cycle length");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule